// File: doc/BRIEF.md
# Interrupt Destination Match Unit

This block sits on the receive side of one CPU's local interrupt controller and decides whether an incoming interrupt message is meant for this CPU. Each message carries a valid strobe, a destination mode (physical or logical) and a 32-bit destination field. A controller variant input picks either the legacy 8-bit ID scheme or the extended 32-bit scheme. Configuration inputs hold the local physical ID, the local logical ID and, for the legacy variant, whether logical addressing uses the flat bitmap model or the cluster model.

There are four addressing schemes. Legacy physical uses an 8-bit ID where all-ones means broadcast. Legacy flat logical uses an 8-bit bitmap. Legacy cluster logical puts a cluster number in the upper nibble and a per-CPU bitmap in the lower nibble. The extended variant puts a 16-bit cluster number over a 16-bit bitmap in logical mode, and uses a full 32-bit ID with an all-ones broadcast in physical mode. The block also reports, combinationally, when the programmed physical ID is above the largest value the selected variant allows.

Top module: `irq_dest_match`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `accept` is 0.
- R2: Legacy physical mode (`ext_mode`=0, `msg_logical`=0): a message is accepted when `msg_dest[7:0]` equals `cfg_phys_id[7:0]`. Bits 31:8 of `msg_dest` are ignored.
- R3: Legacy physical mode: a destination low byte of 0xFF is broadcast and is always accepted.
- R4: Legacy flat logical mode (`msg_logical`=1, `cfg_cluster`=0): a message is accepted when `msg_dest[7:0]` and `cfg_log_id[7:0]` have at least one set bit in common.
- R5: Legacy cluster logical mode (`cfg_cluster`=1): a message is accepted when `msg_dest[7:4]` equals `cfg_log_id[7:4]` and `msg_dest[3:0]` shares a set bit with `cfg_log_id[3:0]`.
- R6: Legacy cluster logical mode: a cluster field `msg_dest[7:4]` of 0xF matches every cluster, but the low-nibble bitmap overlap is still required.
- R7: Extended logical mode (`ext_mode`=1, `msg_logical`=1): a message is accepted when `msg_dest[31:16]` equals `cfg_log_id[31:16]` and `msg_dest[15:0]` shares a set bit with `cfg_log_id[15:0]`. `cfg_cluster` has no effect.
- R8: Extended physical mode: a message is accepted when all 32 bits of `msg_dest` equal `cfg_phys_id`, or when `msg_dest` is 0xFFFFFFFF (broadcast).
- R9: `id_range_err` is 1 in the same cycle when `cfg_phys_id` exceeds 0xFE in legacy mode or 0xFFFFFFFE in extended mode, and 0 otherwise.
- R10: `accept` is registered. It reflects the message presented with `msg_valid`=1 one clock edge later, and it is 0 after any edge at which `msg_valid` was 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Incoming message strobe |
| msg_logical | input | 1 | Destination mode: 1 logical, 0 physical |
| msg_dest | input | 32 | Destination field |
| ext_mode | input | 1 | Variant: 0 legacy 8-bit, 1 extended 32-bit |
| cfg_phys_id | input | 32 | Local physical ID |
| cfg_log_id | input | 32 | Local logical ID |
| cfg_cluster | input | 1 | Legacy logical model: 0 flat, 1 cluster |
| accept | output | 1 | Registered: this CPU is a target |
| id_range_err | output | 1 | Local physical ID above the variant's maximum |

## Verification
The bench sets nonzero upper destination bits in legacy physical mode. A design that compares all 32 bits would then drop messages that should be accepted. It sends a legacy cluster broadcast whose bitmap misses this CPU, which catches a design that lets the 0xF cluster skip the bitmap test. It also sends extended messages with the right bitmap but the wrong cluster, which catches a design that checks only the bitmap. The ID range check is exercised at 0xFE/0xFF and 0xFFFFFFFE/0xFFFFFFFF, so an off-by-one limit shows up, and an idle cycle after each message catches an `accept` that does not clear.

// File: rtl/irq_dest_match.sv
module irq_dest_match #(
  parameter int EXT_W = 32,
  parameter int LEG_W = 8,
  parameter logic [EXT_W-1:0] LEG_MAX_ID = 'hFE,
  parameter logic [EXT_W-1:0] EXT_MAX_ID = 'hFFFF_FFFE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  input  logic             msg_logical,
  input  logic [EXT_W-1:0] msg_dest,
  input  logic             ext_mode,
  input  logic [EXT_W-1:0] cfg_phys_id,
  input  logic [EXT_W-1:0] cfg_log_id,
  input  logic             cfg_cluster,
  output logic             accept,
  output logic             id_range_err
);
  localparam int LH = LEG_W / 2;
  localparam int EH = EXT_W / 2;

  logic [LEG_W-1:0] ld, ll, lp;
  logic leg_phys_hit, leg_flat_hit, leg_clu_hit, ext_phys_hit, ext_log_hit, hit;

  assign ld = msg_dest[LEG_W-1:0];
  assign ll = cfg_log_id[LEG_W-1:0];
  assign lp = cfg_phys_id[LEG_W-1:0];

  assign leg_phys_hit = (ld == '1) || (ld == lp);
  assign leg_flat_hit = |(ld & ll);
  assign leg_clu_hit  = ((ld[LEG_W-1:LH] == '1) || (ld[LEG_W-1:LH] == ll[LEG_W-1:LH]))
                        && |(ld[LH-1:0] & ll[LH-1:0]);
  assign ext_phys_hit = (msg_dest == '1) || (msg_dest == cfg_phys_id);
  assign ext_log_hit  = (msg_dest[EXT_W-1:EH] == cfg_log_id[EXT_W-1:EH])
                        && |(msg_dest[EH-1:0] & cfg_log_id[EH-1:0]);

  always_comb begin
    if (ext_mode) hit = msg_logical ? ext_log_hit : ext_phys_hit;
    else if (!msg_logical) hit = leg_phys_hit;
    else hit = cfg_cluster ? leg_clu_hit : leg_flat_hit;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) accept <= 1'b0;
    else        accept <= msg_valid && hit;

  assign id_range_err = cfg_phys_id > (ext_mode ? EXT_MAX_ID : LEG_MAX_ID);

  assert_idle_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |=> !accept);

  assert_leg_bcast_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !ext_mode && !msg_logical && msg_dest[LEG_W-1:0] == '1) |=> accept);

  assert_ext_bcast_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && ext_mode && !msg_logical && msg_dest == '1) |=> accept);

  assert_clu_nobit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !ext_mode && msg_logical && cfg_cluster
     && msg_dest[LH-1:0] == '0) |=> !accept);

  assert_ext_nobit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && ext_mode && msg_logical && msg_dest[EH-1:0] == '0) |=> !accept);

  assert_leg_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && cfg_phys_id[LEG_W-1:0] == '1) |-> id_range_err);

  assert_reset_low_R1: assert property (@(posedge clk) !rst_n |=> !accept);
endmodule

// File: tb/irq_dest_match_tb.sv
module irq_dest_match_tb;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic msg_valid = 1'b0, msg_logical = 1'b0, ext_mode = 1'b0, cfg_cluster = 1'b0;
  logic [31:0] msg_dest = '0, cfg_phys_id = '0, cfg_log_id = '0;
  logic accept, id_range_err;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dest_match u_dut (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_logical(msg_logical),
    .msg_dest(msg_dest), .ext_mode(ext_mode), .cfg_phys_id(cfg_phys_id),
    .cfg_log_id(cfg_log_id), .cfg_cluster(cfg_cluster),
    .accept(accept), .id_range_err(id_range_err));

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic send(string req, logic ext, logic lg, logic [31:0] dest, logic exp);
    @(negedge clk);
    ext_mode = ext; msg_logical = lg; msg_dest = dest; msg_valid = 1'b1;
    @(negedge clk);
    check(req, accept, exp);
    msg_valid = 1'b0;
    @(negedge clk);
    check("R10", accept, 1'b0);
  endtask

  task automatic t_reset();
    #1;
    check("R1", accept, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", accept, 1'b0);
  endtask

  task automatic t_leg_phys();
    cfg_phys_id = 32'h23;
    send("R2", 0, 0, 32'h23, 1);
    send("R2", 0, 0, 32'h24, 0);
    send("R2", 0, 0, 32'hABCD_EF23, 1);
    cfg_cluster = 1'b1;
    send("R2", 0, 0, 32'h23, 1);
    cfg_cluster = 1'b0;
    send("R3", 0, 0, 32'hFF, 1);
    send("R3", 0, 0, 32'h1234_56FF, 1);
  endtask

  task automatic t_flat();
    cfg_cluster = 1'b0; cfg_log_id = 32'h04;
    send("R4", 0, 1, 32'h0C, 1);
    send("R4", 0, 1, 32'hF3, 0);
    send("R4", 0, 1, 32'h04, 1);
  endtask

  task automatic t_cluster();
    cfg_cluster = 1'b1; cfg_log_id = 32'h52;
    send("R5", 0, 1, 32'h53, 1);
    send("R5", 0, 1, 32'h51, 0);
    send("R5", 0, 1, 32'h62, 0);
    send("R6", 0, 1, 32'hF2, 1);
    send("R6", 0, 1, 32'hF1, 0);
  endtask

  task automatic t_ext_log();
    cfg_log_id = 32'h0003_0010;
    cfg_cluster = 1'b0;
    send("R7", 1, 1, 32'h0003_0030, 1);
    send("R7", 1, 1, 32'h0004_0010, 0);
    send("R7", 1, 1, 32'h0003_0001, 0);
    cfg_cluster = 1'b1;
    send("R7", 1, 1, 32'h0003_0010, 1);
  endtask

  task automatic t_ext_phys();
    cfg_phys_id = 32'h0001_2345;
    send("R8", 1, 0, 32'h0001_2345, 1);
    send("R8", 1, 0, 32'h0000_2345, 0);
    send("R8", 1, 0, 32'hFFFF_FFFF, 1);
  endtask

  task automatic t_range();
    @(negedge clk);
    ext_mode = 1'b0; cfg_phys_id = 32'hFE; #1 check("R9", id_range_err, 0);
    cfg_phys_id = 32'hFF;       #1 check("R9", id_range_err, 1);
    cfg_phys_id = 32'h100;      #1 check("R9", id_range_err, 1);
    ext_mode = 1'b1;            #1 check("R9", id_range_err, 0);
    cfg_phys_id = 32'hFFFF_FFFE; #1 check("R9", id_range_err, 0);
    cfg_phys_id = 32'hFFFF_FFFF; #1 check("R9", id_range_err, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_leg_phys();
        t_flat();
        t_cluster();
        t_ext_log();
        t_ext_phys();
        t_range();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule